// File: doc/BRIEF.md
# Programmable 16-bit Counter/Timer

The block is a 16-bit down-counter that is loaded from a time-constant register when it is triggered. It counts down one step per enabled count event and signals terminal count when the last step is taken. In single-cycle operation it then stops. In continuous operation it reloads and carries on. Count events are normally the system clock. They can instead be rising edges on an external count pin, or rising edges of a neighbouring timer's output. Counting only advances while the gating conditions are all true.

The block can be started by three sources: a software trigger written over the host bus, an external trigger pin, or the neighbouring timer's output. When retriggering is enabled, a new trigger during a count restarts the count from the time constant.

The waveform output can be a single pulse on the last count period, a one-shot level from trigger to terminal count, or a square wave. A read-latch flag freezes a snapshot of the count, so that the two bytes can be read as one consistent value. The host sees seven byte-wide registers on a small strobe-based bus. The block also emits a one-cycle terminal-count event for use elsewhere.

Top module: `pct_timer`

Register addresses:

| Address | Register |
|---|---|
| 0 | mode |
| 1 | command/status |
| 2 | time-constant high byte |
| 3 | time-constant low byte |
| 4 | count high byte (read only) |
| 5 | count low byte (read only) |
| 6 | link select (bits 1:0) |
| 7 | unused, reads 0 |

Mode register bits:

| Bit | Function |
|---|---|
| 7 | continuous operation |
| 6 | drive `tmr_out` |
| 5 | external count enable |
| 4 | external trigger enable |
| 3 | external gate enable |
| 2 | retrigger enable |
| 1:0 | output shape |

Command/status bits:

| Bit | Write | Read |
|---|---|---|
| 3 | set the read latch | latch flag |
| 2 | software gate | software gate |
| 1 | software trigger | always 0 |
| 0 | none | count in progress |

## Requirements
- R1: After reset, every register reads 0, the status reads 0 (idle), and `tmr_out`, `chain_out` and `tc_evt` are 0.
- R2: An accepted trigger loads the time constant and sets status bit 0 at the same edge. The count then falls by one per enabled step. The step that moves the count from 1 ends the count, and `tc_evt` is high for exactly the following cycle.
- R3: With mode bit 7 = 0 the block stops at terminal count: status bit 0 clears and the count reads 0. With mode bit 7 = 1 it reloads the time constant at terminal count and keeps running.
- R4: The count holds while the software gate (command bit 2) is 0, or while mode bit 3 = 1 and `ext_gate` is 0. With mode bit 3 = 0, `ext_gate` has no effect.
- R5: With mode bit 2 = 1, a trigger during a count reloads the time constant and wins over a same-cycle count step. With mode bit 2 = 0, such a trigger is ignored and the step proceeds.
- R6: The wave shape follows mode bits 1:0. Shape 0 (pulse) is high while the count is 1. Shape 1 (one-shot) is high from trigger to terminal count. Shape 2 (square) starts low at a fresh trigger and toggles at each terminal count. Shape 3 (reserved) stays low.
- R7: `chain_out` always carries the wave. `tmr_out` carries it only when mode bit 6 = 1 and is 0 otherwise.
- R8: A time constant of 0 gives 65536 count steps before terminal count.
- R9: Writing the time constant during a count leaves the running count unchanged. The new value is used at the next reload.
- R10: Writing command bit 3 = 1 snapshots the count and sets status bit 3. While the flag is set, addresses 4 and 5 return the snapshot. A read of address 5 clears the flag, and later reads return the live count.
- R11: Command bit 1 reads as 0 at all times, and command bit 2 reads back the written software gate.
- R12: With mode bit 4 = 1, a rising edge on `ext_trig` triggers at the next clock edge. A level held high does not trigger again. With mode bit 4 = 0, `ext_trig` is ignored.
- R13: With mode bit 5 = 1, the count advances one step per rising edge of `ext_cnt` instead of per clock.
- R14: Link select 1 makes `link_in` an additional gate. Link select 2 makes a rising edge of `link_in` a trigger. Link select 3 makes each rising edge of `link_in` one count step. Link select 0 ignores `link_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on address 5) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| ext_trig | input | 1 | External trigger, rising edge |
| ext_gate | input | 1 | External gate level |
| ext_cnt | input | 1 | External count input, rising edge |
| link_in | input | 1 | Output of a neighbouring timer |
| tmr_out | output | 1 | Wave, qualified by mode bit 6 |
| chain_out | output | 1 | Wave, unqualified, for chaining |
| tc_evt | output | 1 | One-cycle terminal-count event |

## Verification
A trigger and a count step can land in the same clock cycle. With retriggering enabled, the bench provokes this with a software trigger written while the gate is open and the counter is stepping on every clock, so the edge that accepts the trigger would also have decremented. It judges the outcome by reading the count right afterwards:
- with retriggering enabled, the reading must equal the full time constant;
- with retriggering disabled, the reading must show the step taken and the trigger dropped.

// File: rtl/pct_pkg.sv
package pct_pkg;

    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int RUN_W  = CNT_W + 1;

    typedef enum logic [1:0] {
        SHP_PULSE   = 2'd0,
        SHP_ONESHOT = 2'd1,
        SHP_SQUARE  = 2'd2,
        SHP_RSVD    = 2'd3
    } shape_e;

    typedef enum logic [1:0] {
        LNK_OFF   = 2'd0,
        LNK_GATE  = 2'd1,
        LNK_TRIG  = 2'd2,
        LNK_CLOCK = 2'd3
    } link_e;

    // bit order of the packed struct is the mode register layout, MSB first
    typedef struct packed {
        logic   cont;
        logic   out_en;
        logic   cnt_en;
        logic   trg_en;
        logic   gate_en;
        logic   retrig;
        shape_e shape;
    } mode_t;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE   = 3'd0,
        A_CMD    = 3'd1,
        A_TC_HI  = 3'd2,
        A_TC_LO  = 3'd3,
        A_CNT_HI = 3'd4,
        A_CNT_LO = 3'd5,
        A_LINK   = 3'd6,
        A_SPARE  = 3'd7
    } addr_e;

    localparam int CMD_LATCH = 3;
    localparam int CMD_GATE  = 2;
    localparam int CMD_TRIG  = 1;
    localparam int ST_RUN    = 0;

    typedef struct packed {
        logic trig;
        logic step;
    } ctl_t;

    // zero time constant stands for the full 2**CNT_W range
    function automatic logic [RUN_W-1:0] load_value(input logic [CNT_W-1:0] tc);
        return (tc == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, tc};
    endfunction

endpackage

// File: rtl/pct_regs.sv
module pct_regs
    import pct_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt_now,
    input  logic              run,
    output mode_t             mode,
    output logic [CNT_W-1:0]  tc,
    output link_e             link,
    output logic              sw_gate,
    output logic              sw_trig
);

    mode_t            mode_q;
    logic [CNT_W-1:0] tc_q;
    link_e            link_q;
    logic             gate_q;
    logic             latch_q;
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] view;
    addr_e            sel;

    assign sel     = addr_e'(bus_addr);
    assign sw_trig = bus_wr && (sel == A_CMD) && bus_wdata[CMD_TRIG];
    assign mode    = mode_q;
    assign tc      = tc_q;
    assign link    = link_q;
    assign sw_gate = gate_q;
    assign view    = latch_q ? hold_q : cnt_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            tc_q    <= '0;
            link_q  <= LNK_OFF;
            gate_q  <= 1'b0;
            latch_q <= 1'b0;
            hold_q  <= '0;
        end else if (bus_wr) begin
            case (sel)
                A_MODE:  mode_q <= mode_t'(bus_wdata);
                A_CMD: begin
                    gate_q <= bus_wdata[CMD_GATE];
                    if (bus_wdata[CMD_LATCH] && !latch_q) begin
                        latch_q <= 1'b1;
                        hold_q  <= cnt_now;
                    end
                end
                A_TC_HI: tc_q[CNT_W-1:BYTE_W] <= bus_wdata;
                A_TC_LO: tc_q[BYTE_W-1:0]     <= bus_wdata;
                A_LINK:  link_q <= link_e'(bus_wdata[1:0]);
                default: ;
            endcase
        end else if (bus_rd && (sel == A_CNT_LO)) begin
            latch_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            A_MODE:   bus_rdata = mode_q;
            A_CMD: begin
                bus_rdata[CMD_LATCH] = latch_q;
                bus_rdata[CMD_GATE]  = gate_q;
                bus_rdata[ST_RUN]    = run;
            end
            A_TC_HI:  bus_rdata = tc_q[CNT_W-1:BYTE_W];
            A_TC_LO:  bus_rdata = tc_q[BYTE_W-1:0];
            A_CNT_HI: bus_rdata = view[CNT_W-1:BYTE_W];
            A_CNT_LO: bus_rdata = view[BYTE_W-1:0];
            A_LINK:   bus_rdata[1:0] = link_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pct_evsel.sv
module pct_evsel
    import pct_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_t mode,
    input  link_e link,
    input  logic  sw_trig,
    input  logic  sw_gate,
    input  logic  ext_trig,
    input  logic  ext_gate,
    input  logic  ext_cnt,
    input  logic  link_in,
    output ctl_t  ctl
);

    logic trg_q, cnt_q, lnk_q;
    logic trg_rise, cnt_rise, lnk_rise;
    logic tick, gate_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            trg_q <= 1'b0;
            cnt_q <= 1'b0;
            lnk_q <= 1'b0;
        end else begin
            trg_q <= ext_trig;
            cnt_q <= ext_cnt;
            lnk_q <= link_in;
        end
    end

    assign trg_rise = ext_trig && !trg_q;
    assign cnt_rise = ext_cnt  && !cnt_q;
    assign lnk_rise = link_in  && !lnk_q;

    always_comb begin
        if (link == LNK_CLOCK)  tick = lnk_rise;
        else if (mode.cnt_en)   tick = cnt_rise;
        else                    tick = 1'b1;
        gate_ok  = sw_gate
                 && (!mode.gate_en || ext_gate)
                 && ((link != LNK_GATE) || link_in);
        ctl.step = gate_ok && tick;
        ctl.trig = sw_trig
                 || (mode.trg_en && trg_rise)
                 || ((link == LNK_TRIG) && lnk_rise);
    end

endmodule

// File: rtl/pct_core.sv
module pct_core
    import pct_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  mode_t            mode,
    input  logic [CNT_W-1:0] tc,
    input  ctl_t             ctl,
    output logic [RUN_W-1:0] cnt,
    output logic             run,
    output logic             wave,
    output logic             tc_evt
);

    logic [RUN_W-1:0] cnt_q;
    logic             run_q, wave_q, tcev_q;
    logic             accept, finish;

    assign accept = ctl.trig && (!run_q || mode.retrig);
    assign finish = run_q && ctl.step && !accept && (cnt_q == RUN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            run_q  <= 1'b0;
            wave_q <= 1'b0;
            tcev_q <= 1'b0;
        end else begin
            tcev_q <= finish;
            if (accept) begin
                cnt_q <= load_value(tc);
                run_q <= 1'b1;
                if (!run_q)
                    wave_q <= (mode.shape == SHP_ONESHOT);
                else if (mode.shape == SHP_ONESHOT)
                    wave_q <= 1'b1;
            end else if (finish) begin
                if (mode.cont) begin
                    cnt_q <= load_value(tc);
                end else begin
                    cnt_q <= '0;
                    run_q <= 1'b0;
                end
                case (mode.shape)
                    SHP_SQUARE: wave_q <= !wave_q;
                    default:    wave_q <= 1'b0;
                endcase
            end else if (run_q && ctl.step) begin
                cnt_q <= cnt_q - RUN_W'(1);
            end
        end
    end

    always_comb begin
        case (mode.shape)
            SHP_PULSE:   wave = run_q && (cnt_q == RUN_W'(1));
            SHP_ONESHOT: wave = wave_q;
            SHP_SQUARE:  wave = wave_q;
            default:     wave = 1'b0;
        endcase
    end

    assign cnt    = cnt_q;
    assign run    = run_q;
    assign tc_evt = tcev_q;

endmodule

// File: rtl/pct_timer.sv
module pct_timer
    import pct_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_trig,
    input  logic              ext_gate,
    input  logic              ext_cnt,
    input  logic              link_in,
    output logic              tmr_out,
    output logic              chain_out,
    output logic              tc_evt
);

    mode_t            mode_w;
    logic [CNT_W-1:0] tc_w;
    link_e            link_w;
    logic             sw_gate_w, sw_trig_w;
    ctl_t             ctl_w;
    logic [RUN_W-1:0] cnt_w;
    logic             run_w, wave_w;

    pct_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_now   (cnt_w[CNT_W-1:0]),
        .run       (run_w),
        .mode      (mode_w),
        .tc        (tc_w),
        .link      (link_w),
        .sw_gate   (sw_gate_w),
        .sw_trig   (sw_trig_w)
    );

    pct_evsel u_evsel (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_w),
        .link     (link_w),
        .sw_trig  (sw_trig_w),
        .sw_gate  (sw_gate_w),
        .ext_trig (ext_trig),
        .ext_gate (ext_gate),
        .ext_cnt  (ext_cnt),
        .link_in  (link_in),
        .ctl      (ctl_w)
    );

    pct_core u_core (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode_w),
        .tc     (tc_w),
        .ctl    (ctl_w),
        .cnt    (cnt_w),
        .run    (run_w),
        .wave   (wave_w),
        .tc_evt (tc_evt)
    );

    assign chain_out = wave_w;
    assign tmr_out   = mode_w.out_en && wave_w;

endmodule

// File: rtl/pct_checker.sv
module pct_checker
    import pct_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input ctl_t              ctl_w,
    input logic              run_w,
    input logic [RUN_W-1:0]  cnt_w,
    input logic [CNT_W-1:0]  tc_w,
    input mode_t             mode_w,
    input logic              tc_evt,
    input logic              tmr_out,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_rdata
);

    assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl_w.trig && !run_w) |=> (run_w && cnt_w == (($past(tc_w) == '0)
            ? {1'b1, {CNT_W{1'b0}}} : {1'b0, $past(tc_w)})));

    assert_tc_event_R2: assert property (@(posedge clk) disable iff (rst)
        (run_w && ctl_w.step && !ctl_w.trig && cnt_w == RUN_W'(1)) |=> tc_evt);

    assert_single_stops_R3: assert property (@(posedge clk) disable iff (rst)
        (run_w && !mode_w.cont && ctl_w.step && !ctl_w.trig && cnt_w == RUN_W'(1)) |=> !run_w);

    assert_hold_no_step_R4: assert property (@(posedge clk) disable iff (rst)
        (run_w && !ctl_w.trig && !ctl_w.step) |=> $stable(cnt_w));

    assert_no_retrig_R5: assert property (@(posedge clk) disable iff (rst)
        (run_w && ctl_w.trig && !mode_w.retrig && !ctl_w.step) |=> $stable(cnt_w));

    assert_out_qualified_R7: assert property (@(posedge clk) disable iff (rst)
        !mode_w.out_en |-> !tmr_out);

    assert_count_range_R8: assert property (@(posedge clk) disable iff (rst)
        run_w |-> (cnt_w != '0 && cnt_w <= {1'b1, {CNT_W{1'b0}}}));

    assert_trig_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd1) |-> !bus_rdata[1]);

endmodule

bind pct_timer pct_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_w     (ctl_w),
    .run_w     (run_w),
    .cnt_w     (cnt_w),
    .tc_w      (tc_w),
    .mode_w    (mode_w),
    .tc_evt    (tc_evt),
    .tmr_out   (tmr_out),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/test_pct_timer.sv
module test_pct_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_trig = 1'b0, ext_gate = 1'b0, ext_cnt = 1'b0, link_in = 1'b0;
    logic       tmr_out, chain_out, tc_evt;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_fail = 0;

    always #2 clk = ~clk;

    pct_timer i_pct_timer (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_trig(ext_trig), .ext_gate(ext_gate), .ext_cnt(ext_cnt),
        .link_in(link_in), .tmr_out(tmr_out), .chain_out(chain_out),
        .tc_evt(tc_evt)
    );

    // monitor: pops one expectation per read strobe, mid-cycle
    always @(negedge clk) begin
        exp_t e;
        if (bus_rd) begin
            n_chk++;
            if (sbq.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard underflow: addr %0d actual %02h expected none", bus_addr, bus_rdata);
            end else begin
                e = sbq.pop_front();
                if (bus_rdata !== e.exp) begin
                    n_fail++;
                    $display("FAIL %s: addr %0d actual %02h expected %02h", e.tag, bus_addr, bus_rdata, e.exp);
                end
            end
        end
    end

    // all tasks start and end 1 ns after a rising edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        it.exp = e; it.tag = tag;
        sbq.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_tc(input logic [15:0] v);
        wr(3'd2, v[15:8]);
        wr(3'd3, v[7:0]);
    endtask

    task automatic chk(input string tag, input logic act, input logic e);
        n_chk++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, e);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(3'd1, 8'h00, "R1 status");
        rd(3'd0, 8'h00, "R1 mode");
        rd(3'd5, 8'h00, "R1 count");
        chk("R1 tmr_out", tmr_out, 1'b0);
        chk("R1 chain_out", chain_out, 1'b0);
        chk("R1 tc_evt", tc_evt, 1'b0);

        // R11 gate readable, trigger bit reads 0; R2/R6 pulse single
        wr(3'd1, 8'h04);
        rd(3'd1, 8'h04, "R11 gate readback");
        wr(3'd0, 8'h40);
        set_tc(16'd5);
        wr(3'd1, 8'h06);
        rd(3'd5, 8'h05, "R2 load");
        rd(3'd5, 8'h04, "R2 decrement");
        idle(2);
        chk("R6 pulse high at count 1", tmr_out, 1'b1);
        chk("R2 no early tc", tc_evt, 1'b0);
        idle(1);
        chk("R2 tc_evt", tc_evt, 1'b1);
        chk("R6 pulse ends", tmr_out, 1'b0);
        rd(3'd1, 8'h04, "R3 single stop / R11 trig reads 0");
        chk("R2 tc_evt one cycle", tc_evt, 1'b0);
        rd(3'd5, 8'h00, "R3 count zero");

        // R6 square, R3 continuous, R4 software gate
        wr(3'd0, 8'hC2);
        set_tc(16'd2);
        wr(3'd1, 8'h06);
        chk("R6 square starts low", tmr_out, 1'b0);
        idle(2);
        chk("R6 square toggles", tmr_out, 1'b1);
        chk("R3 tc in continuous", tc_evt, 1'b1);
        rd(3'd5, 8'h02, "R3 reload");
        idle(1);
        chk("R6 square toggles back", tmr_out, 1'b0);
        wr(3'd1, 8'h00);
        rd(3'd5, 8'h01, "R4 gate off freeze");
        idle(3);
        rd(3'd5, 8'h01, "R4 gate off hold");
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h04);
        idle(4);
        rd(3'd1, 8'h04, "R3 stopped");

        // R5 retrigger, R6 one-shot, R7 output qualify
        wr(3'd0, 8'h05);
        set_tc(16'd4);
        wr(3'd1, 8'h06);
        chk("R7 chain_out one-shot", chain_out, 1'b1);
        chk("R7 tmr_out disabled", tmr_out, 1'b0);
        idle(1);
        wr(3'd1, 8'h06);
        rd(3'd5, 8'h04, "R5 retrigger wins over step");
        chk("R6 one-shot held", chain_out, 1'b1);
        idle(2);
        chk("R6 one-shot before tc", chain_out, 1'b1);
        idle(1);
        chk("R6 one-shot ends at tc", chain_out, 1'b0);
        chk("R2 tc after retrigger", tc_evt, 1'b1);

        wr(3'd0, 8'h01);
        set_tc(16'd6);
        wr(3'd1, 8'h06);
        idle(1);
        wr(3'd1, 8'h06);
        rd(3'd5, 8'h04, "R5 trigger ignored without retrigger");
        idle(8);

        wr(3'd0, 8'h41);
        set_tc(16'd2);
        wr(3'd1, 8'h06);
        chk("R7 tmr_out enabled", tmr_out, 1'b1);
        idle(4);

        // R6 reserved shape
        wr(3'd0, 8'h43);
        wr(3'd1, 8'h06);
        chk("R6 reserved low", tmr_out, 1'b0);
        idle(1);
        chk("R6 reserved low running", chain_out, 1'b0);
        idle(3);

        // R9 time-constant write during count
        wr(3'd0, 8'h80);
        set_tc(16'd3);
        wr(3'd1, 8'h06);
        wr(3'd3, 8'h07);
        rd(3'd5, 8'h02, "R9 count undisturbed");
        idle(1);
        rd(3'd5, 8'h07, "R9 new value at reload");
        wr(3'd0, 8'h00);
        idle(10);

        // R10 read latch
        set_tc(16'h0123);
        wr(3'd1, 8'h06);
        wr(3'd1, 8'h0C);
        rd(3'd1, 8'h0D, "R10 latch flag");
        idle(3);
        rd(3'd4, 8'h01, "R10 frozen high");
        rd(3'd5, 8'h23, "R10 frozen low");
        rd(3'd1, 8'h05, "R10 flag cleared");
        rd(3'd5, 8'h1B, "R10 live count");
        idle(300);

        // R4 external gate
        wr(3'd0, 8'h08);
        set_tc(16'd3);
        wr(3'd1, 8'h06);
        idle(3);
        rd(3'd5, 8'h03, "R4 ext gate low holds");
        wr(3'd0, 8'h00);
        rd(3'd5, 8'h03, "R4 ext gate disabled");
        rd(3'd5, 8'h02, "R4 ext gate ignored");
        idle(4);

        // R12 external trigger
        wr(3'd0, 8'h10);
        set_tc(16'd2);
        ext_trig = 1'b1;
        idle(1);
        rd(3'd1, 8'h05, "R12 ext trigger");
        idle(2);
        rd(3'd1, 8'h04, "R12 level no retrigger");
        ext_trig = 1'b0;
        idle(1);
        wr(3'd0, 8'h00);
        ext_trig = 1'b1;
        idle(2);
        rd(3'd1, 8'h04, "R12 disabled ignored");
        ext_trig = 1'b0;

        // R13 external count
        wr(3'd0, 8'h20);
        set_tc(16'd3);
        wr(3'd1, 8'h06);
        idle(3);
        rd(3'd5, 8'h03, "R13 no clock counting");
        for (int i = 0; i < 2; i++) begin
            ext_cnt = 1'b1; idle(1); ext_cnt = 1'b0; idle(1);
        end
        rd(3'd5, 8'h01, "R13 two edges");
        ext_cnt = 1'b1; idle(1); ext_cnt = 1'b0; idle(1);
        rd(3'd1, 8'h04, "R13 finished");

        // R14 link modes
        wr(3'd0, 8'h00);
        wr(3'd6, 8'h03);
        set_tc(16'd2);
        wr(3'd1, 8'h06);
        rd(3'd5, 8'h02, "R14 link clock loaded");
        link_in = 1'b1; idle(1); link_in = 1'b0; idle(1);
        rd(3'd5, 8'h01, "R14 link clock step");
        link_in = 1'b1; idle(1); link_in = 1'b0; idle(1);
        rd(3'd1, 8'h04, "R14 link clock done");

        wr(3'd6, 8'h02);
        link_in = 1'b1;
        idle(1);
        rd(3'd1, 8'h05, "R14 link trigger");
        link_in = 1'b0;
        idle(4);
        rd(3'd1, 8'h04, "R14 link trigger done");

        wr(3'd6, 8'h01);
        set_tc(16'd3);
        wr(3'd1, 8'h06);
        idle(3);
        rd(3'd5, 8'h03, "R14 link gate closed");
        link_in = 1'b1;
        idle(1);
        rd(3'd5, 8'h02, "R14 link gate open");
        idle(5);
        link_in = 1'b0;
        wr(3'd6, 8'h00);

        // R8 zero time constant = 65536 steps
        set_tc(16'd0);
        wr(3'd1, 8'h06);
        rd(3'd4, 8'h00, "R8 load high byte");
        idle(65533);
        rd(3'd5, 8'h02, "R8 near end");
        rd(3'd1, 8'h05, "R8 still running");
        rd(3'd1, 8'h04, "R8 ended after 65536");

        idle(2);
        summary();
        $finish;
    end

endmodule